// File: doc/BRIEF.md
# Up/Down Timer with Match-Driven PWM

This block is a general-purpose timer with a counter of parameterized width (16 bits by default) that steps by one in either direction. When the counter reaches its terminal value, it raises a timeout event. The terminal value is zero when counting down and all-ones when counting up. On a timeout the counter reloads from a programmed value and keeps running, so the reload value sets the period.

Two sticky status flags record what has happened. One marks a timeout and the other marks a pending capture. A capture strobe latches the running count. A single clear strobe drops both flags.

A PWM pin runs in one of two modes. In toggle mode the pin inverts on every timeout. In match mode the pin goes active on the cycle after the count equals a programmed match value, and returns to its idle level after a timeout. The idle level is programmable, and the active level is its inverse.

An optional external event input, when its enable is set, restarts the count from the reload value. A status output is high while that restart is taking place.

Top module: `updn_timer`

## Requirements
- R1: While `rst` is high at a rising edge, the next state is `count`=0, `timeout_flag`=0, `cap_pend`=0, `cap_val`=0 and `pwm_out`=0.
- R2: When `en`=0 at an edge, `count` takes `load_val` and `pwm_out` takes `idle_lvl` on that edge.
- R3: When enabled and no reload applies, `count` rises by 1 per cycle if `dir_up`=1 and falls by 1 per cycle if `dir_up`=0, wrapping modulo 2^WIDTH.
- R4: A timeout event is a cycle with `en`=1 in which no event restart applies and `count` is at its terminal value: 0 when `dir_up`=0, or 2^WIDTH-1 when `dir_up`=1. After a timeout event, `count` equals `load_val` on the next edge.
- R5: `timeout_flag` goes to 1 on the edge after a timeout event. It then stays at 1 until an edge with `clr_req`=1 and no timeout event. A timeout event and `clr_req` in the same cycle leave the flag at 1.
- R6: On an edge with `cap_trig`=1, `cap_val` takes the value `count` had before that edge, and `cap_pend` goes to 1. `cap_pend` is cleared by `clr_req`, and a capture in the same cycle as `clr_req` wins.
- R7: With `match_mode`=0 (toggle mode) and `en`=1, `pwm_out` inverts on the edge after each timeout event and holds otherwise.
- R8: With `match_mode`=1 (match mode) and `en`=1, `pwm_out` becomes `~idle_lvl` on the edge after a cycle where `count`==`match_val` without a timeout event. It becomes `idle_lvl` on the edge after a timeout event, and holds otherwise.
- R9: In match mode, a match that falls in the same cycle as a timeout event leaves `pwm_out` at `idle_lvl`. A match value that the count never reaches keeps `pwm_out` at `idle_lvl`.
- R10: When `en`, `evt_rst_en` and `evt_in` are all 1, `evt_rst_busy` is 1 in that same cycle. The next edge reloads `count` from `load_val`, and that cycle is not a timeout event. With `evt_rst_en`=0, `evt_in` has no effect on `count` and `evt_rst_busy` stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| en | input | 1 | Timer run enable |
| dir_up | input | 1 | 1 = count up, 0 = count down |
| load_val | input | WIDTH | Reload value |
| match_val | input | WIDTH | PWM match value |
| match_mode | input | 1 | 0 = toggle mode, 1 = match mode |
| idle_lvl | input | 1 | Inactive PWM level |
| evt_rst_en | input | 1 | Enables restart by external event |
| evt_in | input | 1 | External restart event |
| cap_trig | input | 1 | Capture strobe |
| clr_req | input | 1 | Clears both status flags |
| count | output | WIDTH | Running counter value |
| timeout_flag | output | 1 | Sticky timeout status |
| cap_pend | output | 1 | Capture-pending status |
| cap_val | output | WIDTH | Captured counter value |
| evt_rst_busy | output | 1 | Event restart in progress |
| pwm_out | output | 1 | PWM pin |

## Verification
The assertions take for granted that every input is a known 0 or 1 at each rising edge, and that `rst` is held across the first edge. Relations that look one cycle back, such as a reload compared against the previous `load_val`, are then well defined. The stimulus changes inputs only on falling edges and drives each of them to a defined value from time zero. It reconfigures the reload value, the match value, the direction and the mode during a disabled cycle, so that every run starts from a reloaded count and an idle pin.

// File: rtl/updn_timer_pkg.sv
package updn_timer_pkg;

    typedef enum logic {
        PWM_TOGGLE = 1'b0,
        PWM_MATCH  = 1'b1
    } pwm_mode_e;

    typedef struct packed {
        logic at_term;
        logic evt_reload;
        logic tout;
    } cnt_evt_t;

    function automatic logic term_hit(input logic up, input logic [31:0] cnt,
                                      input logic [31:0] full);
        return up ? (cnt == full) : (cnt == 32'd0);
    endfunction

endpackage

// File: rtl/updn_timer_counter.sv
module updn_timer_counter
    import updn_timer_pkg::*;
#(
    parameter int WIDTH = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             en,
    input  logic             dir_up,
    input  logic [WIDTH-1:0] load_val,
    input  logic             evt_rst_en,
    input  logic             evt_in,
    output logic [WIDTH-1:0] count,
    output cnt_evt_t         ev
);
    localparam logic [WIDTH-1:0] FULL = '1;

    always_comb begin
        ev.evt_reload = en & evt_rst_en & evt_in;
        ev.at_term    = term_hit(dir_up, 32'(count), 32'(FULL));
        ev.tout       = en & ev.at_term & ~ev.evt_reload;
    end

    always_ff @(posedge clk) begin
        if (rst)
            count <= '0;
        else if (!en || ev.evt_reload || ev.tout)
            count <= load_val;
        else if (dir_up)
            count <= count + 1'b1;
        else
            count <= count - 1'b1;
    end

    p_step_up_r3: assert property (@(posedge clk) disable iff (rst)
        (en && dir_up && !ev.tout && !ev.evt_reload) |=> (count - $past(count)) == WIDTH'(1));
    p_step_dn_r3: assert property (@(posedge clk) disable iff (rst)
        (en && !dir_up && !ev.tout && !ev.evt_reload) |=> ($past(count) - count) == WIDTH'(1));
    p_reload_r4: assert property (@(posedge clk) disable iff (rst)
        ev.tout |=> count == $past(load_val));
    p_evt_reload_r10: assert property (@(posedge clk) disable iff (rst)
        ev.evt_reload |=> count == $past(load_val));
endmodule

// File: rtl/updn_timer_flags.sv
module updn_timer_flags #(
    parameter int WIDTH = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tout,
    input  logic             cap_trig,
    input  logic             clr_req,
    input  logic [WIDTH-1:0] count,
    output logic             timeout_flag,
    output logic             cap_pend,
    output logic [WIDTH-1:0] cap_val
);
    always_ff @(posedge clk) begin
        if (rst) begin
            timeout_flag <= 1'b0;
            cap_pend     <= 1'b0;
            cap_val      <= '0;
        end else begin
            if (tout)         timeout_flag <= 1'b1;
            else if (clr_req) timeout_flag <= 1'b0;
            if (cap_trig) begin
                cap_pend <= 1'b1;
                cap_val  <= count;
            end else if (clr_req) begin
                cap_pend <= 1'b0;
            end
        end
    end

    p_tout_set_r5: assert property (@(posedge clk) disable iff (rst)
        tout |=> timeout_flag);
    p_tout_sticky_r5: assert property (@(posedge clk) disable iff (rst)
        (timeout_flag && !clr_req) |=> timeout_flag);
    p_capture_r6: assert property (@(posedge clk) disable iff (rst)
        cap_trig |=> (cap_pend && cap_val == $past(count)));
    p_cap_sticky_r6: assert property (@(posedge clk) disable iff (rst)
        (cap_pend && !clr_req) |=> cap_pend);
endmodule

// File: rtl/updn_timer_pwm.sv
module updn_timer_pwm
    import updn_timer_pkg::*;
#(
    parameter int WIDTH = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             en,
    input  pwm_mode_e        mode,
    input  logic             idle_lvl,
    input  logic [WIDTH-1:0] count,
    input  logic [WIDTH-1:0] match_val,
    input  logic             tout,
    output logic             pwm_out
);
    logic match_hit;

    always_comb match_hit = en && (count == match_val);

    always_ff @(posedge clk) begin
        if (rst)
            pwm_out <= 1'b0;
        else if (!en)
            pwm_out <= idle_lvl;
        else begin
            unique case (mode)
                PWM_TOGGLE: if (tout) pwm_out <= ~pwm_out;
                PWM_MATCH: begin
                    if (tout)           pwm_out <= idle_lvl;
                    else if (match_hit) pwm_out <= ~idle_lvl;
                end
                default: pwm_out <= idle_lvl;
            endcase
        end
    end

    p_idle_dis_r2: assert property (@(posedge clk) disable iff (rst)
        !en |=> pwm_out == $past(idle_lvl));
    p_toggle_r7: assert property (@(posedge clk) disable iff (rst)
        (en && mode == PWM_TOGGLE && tout) |=> pwm_out != $past(pwm_out));
    p_match_hold_r8: assert property (@(posedge clk) disable iff (rst)
        (en && mode == PWM_MATCH && !tout && !match_hit) |=> $stable(pwm_out));
    p_match_release_r9: assert property (@(posedge clk) disable iff (rst)
        (en && mode == PWM_MATCH && tout) |=> pwm_out == $past(idle_lvl));
endmodule

// File: rtl/updn_timer.sv
module updn_timer
    import updn_timer_pkg::*;
#(
    parameter int WIDTH = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             en,
    input  logic             dir_up,
    input  logic [WIDTH-1:0] load_val,
    input  logic [WIDTH-1:0] match_val,
    input  logic             match_mode,
    input  logic             idle_lvl,
    input  logic             evt_rst_en,
    input  logic             evt_in,
    input  logic             cap_trig,
    input  logic             clr_req,
    output logic [WIDTH-1:0] count,
    output logic             timeout_flag,
    output logic             cap_pend,
    output logic [WIDTH-1:0] cap_val,
    output logic             evt_rst_busy,
    output logic             pwm_out
);
    cnt_evt_t  ev;
    pwm_mode_e mode;

    always_comb mode = pwm_mode_e'(match_mode);
    always_comb evt_rst_busy = ev.evt_reload;

    updn_timer_counter #(.WIDTH(WIDTH)) u_cnt (
        .clk(clk), .rst(rst), .en(en), .dir_up(dir_up), .load_val(load_val),
        .evt_rst_en(evt_rst_en), .evt_in(evt_in), .count(count), .ev(ev)
    );

    updn_timer_flags #(.WIDTH(WIDTH)) u_flags (
        .clk(clk), .rst(rst), .tout(ev.tout), .cap_trig(cap_trig),
        .clr_req(clr_req), .count(count), .timeout_flag(timeout_flag),
        .cap_pend(cap_pend), .cap_val(cap_val)
    );

    updn_timer_pwm #(.WIDTH(WIDTH)) u_pwm (
        .clk(clk), .rst(rst), .en(en), .mode(mode), .idle_lvl(idle_lvl),
        .count(count), .match_val(match_val), .tout(ev.tout), .pwm_out(pwm_out)
    );

    p_reset_r1: assert property (@(posedge clk)
        rst |=> (count == '0 && !timeout_flag && !cap_pend && !pwm_out));
endmodule

// File: tb/tb_updn_timer.sv
module tb_updn_timer;
    localparam int W = 4;
    localparam logic [W-1:0] FULL = '1;

    logic clk = 1'b0;
    logic rst = 1'b1, en = 1'b0, dir_up = 1'b0, match_mode = 1'b0, idle_lvl = 1'b0;
    logic evt_rst_en = 1'b0, evt_in = 1'b0, cap_trig = 1'b0, clr_req = 1'b0;
    logic [W-1:0] load_val = '0, match_val = '0;
    logic [W-1:0] count, cap_val;
    logic timeout_flag, cap_pend, evt_rst_busy, pwm_out;

    int n_chk = 0, n_err = 0;
    logic [W-1:0] m_cnt = '0, m_cv = '0;
    logic m_tf = 1'b0, m_cp = 1'b0, m_pwm = 1'b0;

    always #10 clk = ~clk;

    updn_timer #(.WIDTH(W)) dut (
        .clk(clk), .rst(rst), .en(en), .dir_up(dir_up), .load_val(load_val),
        .match_val(match_val), .match_mode(match_mode), .idle_lvl(idle_lvl),
        .evt_rst_en(evt_rst_en), .evt_in(evt_in), .cap_trig(cap_trig),
        .clr_req(clr_req), .count(count), .timeout_flag(timeout_flag),
        .cap_pend(cap_pend), .cap_val(cap_val), .evt_rst_busy(evt_rst_busy),
        .pwm_out(pwm_out)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s act=%0d exp=%0d t=%0t", tag, act, exp, $time);
        end
    endtask

    // One clock: predict from the requirements, step, compare.
    task automatic cycle();
        logic evr, term, tout, hit;
        logic [W-1:0] n_cnt;
        logic n_pwm;
        string ct, pt;
        #1;
        evr  = en & evt_rst_en & evt_in;
        term = dir_up ? (m_cnt == FULL) : (m_cnt == '0);
        tout = en & term & ~evr;
        hit  = en && (m_cnt == match_val);
        chk("R10 busy", 32'(evt_rst_busy), 32'(evr));
        if (!en || evr || tout) n_cnt = load_val;
        else n_cnt = dir_up ? m_cnt + 1'b1 : m_cnt - 1'b1;
        if (!en) n_pwm = idle_lvl;
        else if (!match_mode) n_pwm = tout ? ~m_pwm : m_pwm;
        else if (tout) n_pwm = idle_lvl;
        else if (hit) n_pwm = ~idle_lvl;
        else n_pwm = m_pwm;
        ct = evr ? "R10 count" : tout ? "R4 count" : !en ? "R2 count" : "R3 count";
        pt = !en ? "R2 pwm" : !match_mode ? "R7 pwm" : (tout && hit) ? "R9 pwm" : "R8 pwm";
        if (tout) m_tf = 1'b1; else if (clr_req) m_tf = 1'b0;
        if (cap_trig) begin m_cp = 1'b1; m_cv = m_cnt; end
        else if (clr_req) m_cp = 1'b0;
        m_cnt = n_cnt;
        m_pwm = n_pwm;
        @(posedge clk);
        @(negedge clk);
        chk(ct, 32'(count), 32'(m_cnt));
        chk("R5 timeout_flag", 32'(timeout_flag), 32'(m_tf));
        chk("R6 cap_pend", 32'(cap_pend), 32'(m_cp));
        chk("R6 cap_val", 32'(cap_val), 32'(m_cv));
        chk(pt, 32'(pwm_out), 32'(m_pwm));
    endtask

    task automatic run(input int ncyc, input bit evts);
        for (int k = 0; k < ncyc; k++) begin
            cap_trig = (k % 5 == 2);
            clr_req  = (k % 11 == 7);
            evt_in   = evts && (k % 7 == 3);
            cycle();
        end
        cap_trig = 1'b0; clr_req = 1'b0; evt_in = 1'b0;
    endtask

    initial begin
        #(20 * 200000);
        n_chk++; n_err++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        @(negedge clk);
        repeat (3) @(negedge clk);
        chk("R1 count", 32'(count), 0);
        chk("R1 timeout_flag", 32'(timeout_flag), 0);
        chk("R1 cap_pend", 32'(cap_pend), 0);
        chk("R1 cap_val", 32'(cap_val), 0);
        chk("R1 pwm", 32'(pwm_out), 0);
        rst = 1'b0;

        // Toggle mode sweep over direction, idle level and every reload value
        for (int d = 0; d < 2; d++)
            for (int il = 0; il < 2; il++)
                for (int ld = 0; ld < 16; ld++) begin
                    en = 1'b0; dir_up = d[0]; idle_lvl = il[0]; match_mode = 1'b0;
                    load_val = ld[W-1:0];
                    cycle();
                    en = 1'b1;
                    run(2 * (d ? 16 - ld : ld + 1) + 3, 1'b0);
                end

        // Match mode sweep over every reload and match value
        for (int d = 0; d < 2; d++)
            for (int il = 0; il < 2; il++)
                for (int ld = 0; ld < 16; ld++)
                    for (int mv = 0; mv < 16; mv++) begin
                        en = 1'b0; dir_up = d[0]; idle_lvl = il[0]; match_mode = 1'b1;
                        load_val = ld[W-1:0]; match_val = mv[W-1:0];
                        cycle();
                        en = 1'b1;
                        run(2 * (d ? 16 - ld : ld + 1) + 2, 1'b0);
                        // R9: a match on the terminal value coincides with the timeout
                        if ((d == 0 && mv == 0) || (d == 1 && mv == 15))
                            chk("R9 coincident idle", 32'(pwm_out), 32'(il));
                    end

        // R10: external event restarts, enabled and ignored, both modes
        for (int mm = 0; mm < 2; mm++)
            for (int er = 0; er < 2; er++) begin
                en = 1'b0; dir_up = 1'b0; match_mode = mm[0]; idle_lvl = 1'b0;
                load_val = 4'd9; match_val = 4'd4; evt_rst_en = er[0];
                cycle();
                en = 1'b1;
                run(40, 1'b1);
            end
        evt_rst_en = 1'b0;

        // R5: timeout every cycle with clear held high keeps the flag set
        en = 1'b0; load_val = '0; dir_up = 1'b0; cycle();
        en = 1'b1; clr_req = 1'b1;
        repeat (4) cycle();
        chk("R5 set beats clear", 32'(timeout_flag), 1);
        clr_req = 1'b0; en = 1'b0;
        cycle();

        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule